// File: doc/BRIEF.md
# Branch Resolution Unit

This block decides, for each instruction handed to it, whether control flow leaves the sequential path and, if so, where it goes. Each cycle it may receive one instruction: its opcode, its own address, the 16-bit immediate carried in the second halfword of a long instruction, the value of register A, and the zero, lesser and greater condition flags. One clock edge later it presents a registered redirect strobe, the address that fetch should use next, and the return-link value for the instruction that copies the instruction pointer into a register.

Unconditional jumps take their target either from the immediate or from register A. Conditional jumps test one of three flags, with either polarity. When no jump is taken, the next-address output still carries the sequential successor, so the surrounding pipeline can use one output for both cases. The flags are used in the same cycle as the opcode; the producer must present values that already include the result of the previous instruction. The unit does not generate flags, sequence a flush or fetch.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `redirect`, `link_wr`, `next_ip` and `link_value` are all zero, whatever the other inputs.
- R2: Opcode 0x21 with `in_valid` high always gives `redirect`=1 and `next_ip`=`imm_target` one cycle later.
- R3: Opcode 0x18 with `in_valid` high always gives `redirect`=1 and `next_ip`=`reg_a` one cycle later.
- R4: Opcode 0x22 jumps to `imm_target` when `flag_zero`=1; opcode 0x23 jumps there when `flag_zero`=0.
- R5: Opcode 0x24 jumps to `imm_target` when `flag_less`=1; opcode 0x25 jumps there when `flag_less`=0.
- R6: Opcode 0x26 jumps to `imm_target` when `flag_great`=1; opcode 0x27 jumps there when `flag_great`=0.
- R7: A conditional jump (0x22 to 0x27) whose condition fails gives `redirect`=0 and `next_ip` = `instr_addr`+2, wrapping modulo 2^ADDR_W.
- R8: Any other opcode gives `redirect`=0 regardless of flags, `imm_target` and `reg_a`; `next_ip` is `instr_addr`+1 for opcodes below 0x20 and `instr_addr`+2 for opcodes 0x20 and above, wrapping.
- R9: Every accepted instruction sets `link_value` = `instr_addr`+1 (wrapping); `link_wr` is 1 one cycle after opcode 0x19 and 0 after every other opcode.
- R10: Outputs are registered with one cycle of latency; a cycle with `in_valid`=0 drives `redirect` and `link_wr` to 0 and leaves `next_ip` and `link_value` unchanged.
- R11: The flags are used in the cycle the opcode arrives with no internal storage, so back-to-back conditional jumps each resolve against the flags presented with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| instr_addr | input | ADDR_W | Address of the presented instruction |
| imm_target | input | ADDR_W | Immediate jump target from the second halfword |
| reg_a | input | ADDR_W | Value of register A, the indirect target |
| flag_zero | input | 1 | Zero condition flag |
| flag_less | input | 1 | Lesser condition flag |
| flag_great | input | 1 | Greater condition flag |
| redirect | output | 1 | Control flow leaves the sequential path |
| next_ip | output | ADDR_W | Jump target when redirecting, else sequential successor |
| link_wr | output | 1 | Write `link_value` into register A |
| link_value | output | ADDR_W | Address following the instruction |

## Verification
The bench drives each conditional opcode with its flag both set and clear while the other two flags hold the opposite value, so a design that tested the wrong flag or the wrong polarity would redirect where it should fall through. It checks the sequential successor at the top of the address space, where a missing wrap or a one-word step for a long instruction gives the wrong address. Back-to-back conditional jumps with a flag that changes between them expose a design that delays or latches the flags, and an idle cycle after a jump catches a redirect strobe that lingers or a target that drifts.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_JMPR    = 8'h18;
  localparam logic [OPC_W-1:0] OP_LDIP    = 8'h19;
  localparam logic [OPC_W-1:0] OP_EXT_MIN = 8'h20;
  localparam logic [OPC_W-1:0] OP_JMP     = 8'h21;
  localparam logic [OPC_W-1:0] OP_JCC_LO  = 8'h22;
  localparam logic [OPC_W-1:0] OP_JCC_HI  = 8'h27;

  // How the next address is formed
  typedef enum logic [1:0] {
    K_SEQ = 2'd0,
    K_ABS = 2'd1,
    K_REG = 2'd2,
    K_CND = 2'd3
  } br_kind_e;

  // Flag tested by a conditional jump; value equals opcode bits [2:1]
  typedef enum logic [1:0] {
    F_NONE  = 2'd0,
    F_ZERO  = 2'd1,
    F_LESS  = 2'd2,
    F_GREAT = 2'd3
  } br_flag_e;

  typedef struct packed {
    br_kind_e kind;
    br_flag_e flag;
    logic     invert;
    logic     ext_len;
    logic     link;
  } br_ctl_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output br_ctl_t          ctl
);

  logic in_jcc;

  assign in_jcc = (op >= OP_JCC_LO) && (op <= OP_JCC_HI);

  always_comb begin
    ctl         = '0;
    ctl.kind    = K_SEQ;
    ctl.flag    = F_NONE;
    ctl.ext_len = (op >= OP_EXT_MIN);
    ctl.link    = (op == OP_LDIP);
    if (op == OP_JMP) begin
      ctl.kind = K_ABS;
    end else if (op == OP_JMPR) begin
      ctl.kind = K_REG;
    end else if (in_jcc) begin
      // pairs share bits [2:1]; the odd member of each pair inverts
      ctl.kind   = K_CND;
      ctl.flag   = br_flag_e'(op[2:1]);
      ctl.invert = op[0];
    end
  end

endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
(
  input  br_flag_e flag,
  input  logic     invert,
  input  logic     flag_zero,
  input  logic     flag_less,
  input  logic     flag_great,
  output logic     hit
);

  localparam int NFLAG = 4;

  logic [NFLAG-1:0] flag_vec;
  logic             sel;

  assign flag_vec = {flag_great, flag_less, flag_zero, 1'b0};

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < NFLAG; i++) begin
      if (flag == br_flag_e'(i)) sel = flag_vec[i];
    end
  end

  assign hit = sel ^ invert;

endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  br_ctl_t           ctl,
  input  logic              cond_hit,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [ADDR_W-1:0] imm_target,
  input  logic [ADDR_W-1:0] reg_a,
  output logic              take,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] link_addr
);

  localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(2);

  logic [ADDR_W-1:0] seq_addr;

  assign seq_addr  = instr_addr + (ctl.ext_len ? STEP_LONG : STEP_SHORT);
  assign link_addr = instr_addr + STEP_SHORT;

  always_comb begin
    take      = 1'b0;
    next_addr = seq_addr;
    unique case (ctl.kind)
      K_ABS: begin
        take      = 1'b1;
        next_addr = imm_target;
      end
      K_REG: begin
        take      = 1'b1;
        next_addr = reg_a;
      end
      K_CND: begin
        take      = cond_hit;
        next_addr = cond_hit ? imm_target : seq_addr;
      end
      default: begin
        take      = 1'b0;
        next_addr = seq_addr;
      end
    endcase
  end

endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [ADDR_W-1:0] imm_target,
  input  logic [ADDR_W-1:0] reg_a,
  input  logic              flag_zero,
  input  logic              flag_less,
  input  logic              flag_great,
  output logic              redirect,
  output logic [ADDR_W-1:0] next_ip,
  output logic              link_wr,
  output logic [ADDR_W-1:0] link_value
);

  br_ctl_t           ctl;
  logic              cond_hit;
  logic              take;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] link_addr;

  br_decode u_decode (
    .op  (opcode),
    .ctl (ctl)
  );

  br_cond u_cond (
    .flag       (ctl.flag),
    .invert     (ctl.invert),
    .flag_zero  (flag_zero),
    .flag_less  (flag_less),
    .flag_great (flag_great),
    .hit        (cond_hit)
  );

  br_target #(.ADDR_W(ADDR_W)) u_target (
    .ctl        (ctl),
    .cond_hit   (cond_hit),
    .instr_addr (instr_addr),
    .imm_target (imm_target),
    .reg_a      (reg_a),
    .take       (take),
    .next_addr  (next_addr),
    .link_addr  (link_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect   <= 1'b0;
      link_wr    <= 1'b0;
      next_ip    <= '0;
      link_value <= '0;
    end else begin
      redirect <= in_valid && take;
      link_wr  <= in_valid && ctl.link;
      if (in_valid) begin
        next_ip    <= next_addr;
        link_value <= link_addr;
      end
    end
  end

  AST_JMP_IMM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h21) |=> (redirect && next_ip == $past(imm_target))); // R2

  AST_JMP_REG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h18) |=> (redirect && next_ip == $past(reg_a))); // R3

  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h22 && flag_zero) |=> (redirect && next_ip == $past(imm_target))); // R4

  AST_JZ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h22 && !flag_zero) |=>
      (!redirect && next_ip == ADDR_W'($past(instr_addr) + ADDR_W'(2)))); // R7

  AST_NONJUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode != 8'h18 && (opcode < 8'h21 || opcode > 8'h27)) |=> !redirect); // R8

  AST_LINK_ONLY_LDIP: assert property (@(posedge clk) disable iff (rst)
    link_wr |-> ($past(in_valid) && $past(opcode) == 8'h19)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!redirect && !link_wr && $stable(next_ip) && $stable(link_value))); // R10

endmodule

// File: tb/br_resolve_tb_top.sv
module br_resolve_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NV = 21;

  // {opcode, addr, imm, reg_a, z, l, g, exp_redirect, exp_next, exp_link_wr}
  localparam logic [8+16*3+3+1+16+1-1:0] VEC [NV] = '{
    {8'h21, 16'h0010, 16'h1234, 16'h5555, 3'b000, 1'b1, 16'h1234, 1'b0},
    {8'h18, 16'h0020, 16'h1111, 16'hBEEF, 3'b111, 1'b1, 16'hBEEF, 1'b0},
    {8'h22, 16'h0030, 16'h0400, 16'h0000, 3'b100, 1'b1, 16'h0400, 1'b0},
    {8'h22, 16'h0030, 16'h0400, 16'h0000, 3'b011, 1'b0, 16'h0032, 1'b0},
    {8'h23, 16'h0040, 16'h0500, 16'h0000, 3'b011, 1'b1, 16'h0500, 1'b0},
    {8'h23, 16'h0040, 16'h0500, 16'h0000, 3'b100, 1'b0, 16'h0042, 1'b0},
    {8'h24, 16'h0050, 16'h0600, 16'h0000, 3'b010, 1'b1, 16'h0600, 1'b0},
    {8'h24, 16'h0050, 16'h0600, 16'h0000, 3'b101, 1'b0, 16'h0052, 1'b0},
    {8'h25, 16'h0060, 16'h0700, 16'h0000, 3'b101, 1'b1, 16'h0700, 1'b0},
    {8'h25, 16'h0060, 16'h0700, 16'h0000, 3'b010, 1'b0, 16'h0062, 1'b0},
    {8'h26, 16'h0070, 16'h0800, 16'h0000, 3'b001, 1'b1, 16'h0800, 1'b0},
    {8'h26, 16'h0070, 16'h0800, 16'h0000, 3'b110, 1'b0, 16'h0072, 1'b0},
    {8'h27, 16'h0080, 16'h0900, 16'h0000, 3'b110, 1'b1, 16'h0900, 1'b0},
    {8'h27, 16'h0080, 16'h0900, 16'h0000, 3'b001, 1'b0, 16'h0082, 1'b0},
    {8'h06, 16'h0090, 16'hFFFF, 16'hFFFF, 3'b111, 1'b0, 16'h0091, 1'b0},
    {8'h20, 16'h00A0, 16'h0AAA, 16'h0000, 3'b111, 1'b0, 16'h00A2, 1'b0},
    {8'h19, 16'h00B0, 16'h0CCC, 16'h0DDD, 3'b111, 1'b0, 16'h00B1, 1'b1},
    {8'h23, 16'hFFFF, 16'h0E00, 16'h0000, 3'b100, 1'b0, 16'h0001, 1'b0},
    {8'h28, 16'h00C0, 16'h0F00, 16'h0F00, 3'b111, 1'b0, 16'h00C2, 1'b0},
    {8'h00, 16'hFFFF, 16'h1000, 16'h2000, 3'b111, 1'b0, 16'h0000, 1'b0},
    {8'h21, 16'h0005, 16'h0000, 16'h3333, 3'b000, 1'b1, 16'h0000, 1'b0}
  };

  localparam string VREQ [NV] = '{
    "R2", "R3", "R4", "R7", "R4", "R7", "R5", "R7", "R5", "R7",
    "R6", "R7", "R6", "R7", "R8", "R8", "R9", "R7", "R8", "R8", "R2"
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [7:0]    opcode;
  logic [AW-1:0] instr_addr, imm_target, reg_a;
  logic          flag_zero, flag_less, flag_great;
  logic          redirect, link_wr;
  logic [AW-1:0] next_ip, link_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_resolve #(.ADDR_W(AW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .instr_addr (instr_addr),
    .imm_target (imm_target),
    .reg_a      (reg_a),
    .flag_zero  (flag_zero),
    .flag_less  (flag_less),
    .flag_great (flag_great),
    .redirect   (redirect),
    .next_ip    (next_ip),
    .link_wr    (link_wr),
    .link_value (link_value)
  );

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] op, input logic [AW-1:0] a,
                       input logic [AW-1:0] im, input logic [AW-1:0] ra, input logic [2:0] zlg);
    in_valid   = v;
    opcode     = op;
    instr_addr = a;
    imm_target = im;
    reg_a      = ra;
    {flag_zero, flag_less, flag_great} = zlg;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 8'h21, 16'h0042, 16'hABCD, 16'h1234, 3'b111);
    repeat (3) @(negedge clk);
    // R1: reset state despite a valid jump on the inputs
    check("R1", "redirect", AW'(redirect), 16'h0);
    check("R1", "link_wr", AW'(link_wr), 16'h0);
    check("R1", "next_ip", next_ip, 16'h0);
    check("R1", "link_value", link_value, 16'h0);
    rst = 1'b0;
    drive(1'b0, 8'h00, 16'h0, 16'h0, 16'h0, 3'b000);
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0]    op;
      logic [AW-1:0] a, im, ra, en;
      logic [2:0]    zlg;
      logic          er, el;
      {op, a, im, ra, zlg, er, en, el} = VEC[i];
      drive(1'b1, op, a, im, ra, zlg);
      @(negedge clk);
      check(VREQ[i], "redirect", AW'(redirect), AW'(er));
      check(VREQ[i], "next_ip", next_ip, en);
      check("R9", "link_wr", AW'(link_wr), AW'(el));
      check("R9", "link_value", link_value, AW'(a + 16'h1));
    end

    // R10: idle cycle holds targets and drops strobes
    drive(1'b1, 8'h21, 16'h0200, 16'h7777, 16'h0, 3'b000);
    @(negedge clk);
    check("R2", "redirect", AW'(redirect), 16'h1);
    drive(1'b0, 8'h21, 16'h0300, 16'h9999, 16'h0, 3'b111);
    @(negedge clk);
    check("R10", "redirect idle", AW'(redirect), 16'h0);
    check("R10", "next_ip hold", next_ip, 16'h7777);
    check("R10", "link_value hold", link_value, 16'h0201);
    drive(1'b0, 8'h19, 16'h0300, 16'h9999, 16'h0, 3'b111);
    @(negedge clk);
    check("R10", "link_wr idle", AW'(link_wr), 16'h0);

    // R11: back-to-back conditional jumps, zero flag changing between them
    drive(1'b1, 8'h22, 16'h0400, 16'h4444, 16'h0, 3'b100);
    @(negedge clk);
    check("R11", "first redirect", AW'(redirect), 16'h1);
    check("R11", "first next_ip", next_ip, 16'h4444);
    drive(1'b1, 8'h22, 16'h4444, 16'h5555, 16'h0, 3'b000);
    @(negedge clk);
    check("R11", "second redirect", AW'(redirect), 16'h0);
    check("R11", "second next_ip", next_ip, 16'h4446);
    drive(1'b1, 8'h27, 16'h4446, 16'h6666, 16'h0, 3'b000);
    @(negedge clk);
    check("R11", "third redirect", AW'(redirect), 16'h1);
    check("R11", "third next_ip", next_ip, 16'h6666);

    // R1: reset in mid-stream clears outputs
    rst = 1'b1;
    drive(1'b1, 8'h19, 16'h0700, 16'h0, 16'h0, 3'b000);
    @(negedge clk);
    check("R1", "redirect mid reset", AW'(redirect), 16'h0);
    check("R1", "link_wr mid reset", AW'(link_wr), 16'h0);
    check("R1", "next_ip mid reset", next_ip, 16'h0);
    check("R1", "link_value mid reset", link_value, 16'h0);
    rst = 1'b0;
    drive(1'b0, 8'h00, 16'h0, 16'h0, 16'h0, 3'b000);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule